// File: doc/BRIEF.md
# Ethernet controller interrupt status unit

This unit collects interrupt causes for a network controller. Transmit, receive and link logic signal events with single-cycle pulses on a 32-bit event bus. Each recognised event sets a sticky bit in a status register. A 32-bit enable register selects which causes count. Two summary bits in the status register are rebuilt from the enabled, set causes: a normal summary covers routine completions and an abnormal summary covers errors and link changes. One level-sensitive interrupt line is raised when a summary bit is set and also enabled.

Software clears causes by writing ones to the status register and rewrites the enable register directly. Both registers can be read back through a combinational read port. A soft-reset input returns the unit to its power-up contents. The external active-low reset is asynchronous and is released through a two-flop synchroniser.

Top module: `nic_irq_ctrl`

## Requirements
- R1: After reset, status reads 0xF0000000, enable reads 0xF3FE0000 and irq_o is 0.
- R2: An event pulse on a cause bit (bits 0-14, 26, 27) sets that status bit on the next clock edge, and the bit stays set until it is cleared.
- R3: Event pulses on bits 15-25 and 28-31 have no effect, and those status bits always hold their reset value.
- R4: Status bit 16 (normal summary) is 1 exactly when any of status bits 0, 2, 6, 11, 14 is set and enabled.
- R5: Status bit 15 (abnormal summary) is 1 exactly when any of status bits 1, 3, 4, 5, 7, 8, 9, 10, 12, 13, 26, 27 is set and enabled.
- R6: A write with wr_sel=0 clears each status bit in 0-16, 26, 27 where wr_data is 1 and leaves the others unchanged. The summary bits are rebuilt after the clear, so a summary bit written with 1 stays set while its condition holds.
- R7: A write with wr_sel=1 replaces the enable register, and the summary bits are rebuilt from the new enable value in the same edge.
- R8: irq_o is a registered output. It is 1 one clock after a cycle in which (status AND enable) has bit 15 or bit 16 set, and 0 otherwise.
- R9: If an event pulse and a write-one-to-clear hit the same bit in the same cycle, the bit stays set.
- R10: soft_rst restores the R1 values on the next edge, including irq_o = 0. It takes priority over a simultaneous event or write.
- R11: rd_data shows status when rd_sel=0 and enable when rd_sel=1, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous reset to power-up contents |
| evt_i | input | 32 | Single-cycle event pulses, one per status bit |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 status (clear on one), 1 enable |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read select: 0 status, 1 enable |
| rd_data | output | 32 | Read data |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions check on every cycle that both summary bits match the enabled, set causes. They also check that bits outside the cause groups keep their reset value, that events always land (including against a same-cycle clear), that bits not written with one survive a status write, that irq_o follows the enabled summaries one clock later, and that soft reset restores both registers. Only the bench scenarios show end-to-end register values after specific sequences: a summary re-asserting after it is written with one, an interrupt dropping when only the summary enable is removed, and ignored writes to the fixed upper bits.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;
  localparam int unsigned DW      = 32;
  localparam int unsigned NIS_BIT = 16;
  localparam int unsigned AIS_BIT = 15;

  // routine causes feeding the normal summary
  localparam logic [DW-1:0] NORM_GRP  = 32'h0000_4845;
  // error / link causes feeding the abnormal summary
  localparam logic [DW-1:0] ABN_GRP   = 32'h0C00_37BA;
  localparam logic [DW-1:0] SUMM_MASK = (32'h1 << NIS_BIT) | (32'h1 << AIS_BIT);
  localparam logic [DW-1:0] EVT_MASK  = NORM_GRP | ABN_GRP;
  localparam logic [DW-1:0] CLR_MASK  = EVT_MASK | SUMM_MASK;

  localparam logic [DW-1:0] STAT_RST  = 32'hF000_0000;
  localparam logic [DW-1:0] EN_RST    = 32'hF3FE_0000;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_ENABLE = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/nic_irq_rst_sync.sv
module nic_irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_ns = sync_q[STAGES-1];
endmodule

// File: rtl/nic_irq_enable_reg.sv
module nic_irq_enable_reg #(
  parameter int unsigned     DW      = 32,
  parameter logic [DW-1:0]   RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rst_ns,
  input  logic          soft_rst,
  input  logic          wr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] en_d,
  output logic [DW-1:0] en_q
);
  logic upd;

  always_comb begin
    upd  = soft_rst | wr;
    en_d = en_q;
    if (soft_rst)  en_d = RST_VAL;
    else if (wr)   en_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)  en_q <= RST_VAL;
    else if (upd) en_q <= en_d;
  end
endmodule

// File: rtl/nic_irq_summary.sv
module nic_irq_summary #(
  parameter int unsigned   DW       = 32,
  parameter logic [DW-1:0] NORM_GRP = '0,
  parameter logic [DW-1:0] ABN_GRP  = '0
) (
  input  logic [DW-1:0] causes,
  input  logic [DW-1:0] enables,
  output logic          norm_sum,
  output logic          abn_sum
);
  logic [DW-1:0] live;

  always_comb begin
    live     = causes & enables;
    norm_sum = |(live & NORM_GRP);
    abn_sum  = |(live & ABN_GRP);
  end
endmodule

// File: rtl/nic_irq_status_reg.sv
module nic_irq_status_reg #(
  parameter int unsigned   DW       = 32,
  parameter logic [DW-1:0] RST_VAL  = '0,
  parameter logic [DW-1:0] EVT_MASK = '0,
  parameter logic [DW-1:0] CLR_MASK = '0,
  parameter int unsigned   NIS_BIT  = 16,
  parameter int unsigned   AIS_BIT  = 15
) (
  input  logic          clk,
  input  logic          rst_ns,
  input  logic          soft_rst,
  input  logic [DW-1:0] evt,
  input  logic          clr_wr,
  input  logic [DW-1:0] clr_data,
  input  logic          en_wr,
  input  logic          norm_sum,
  input  logic          abn_sum,
  output logic [DW-1:0] causes_nxt,
  output logic [DW-1:0] status_q
);
  logic [DW-1:0] evt_m;
  logic [DW-1:0] clr_m;
  logic [DW-1:0] merged;
  logic [DW-1:0] status_d;
  logic          upd;

  // events are applied after the clear, so a same-cycle event wins
  always_comb begin
    evt_m      = evt & EVT_MASK;
    clr_m      = clr_wr ? (clr_data & CLR_MASK) : '0;
    causes_nxt = (status_q & ~clr_m) | evt_m;
    upd        = soft_rst | clr_wr | en_wr | (|evt_m);
  end

  for (genvar b = 0; b < DW; b++) begin : g_bit
    if (b == NIS_BIT) begin : g_nis
      assign merged[b] = norm_sum;
    end else if (b == AIS_BIT) begin : g_ais
      assign merged[b] = abn_sum;
    end else begin : g_cause
      assign merged[b] = causes_nxt[b];
    end
  end

  assign status_d = soft_rst ? RST_VAL : merged;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)  status_q <= RST_VAL;
    else if (upd) status_q <= status_d;
  end
endmodule

// File: rtl/nic_irq_ctrl.sv
module nic_irq_ctrl
  import nic_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic [DW-1:0] evt_i,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_sel,
  output logic [DW-1:0] rd_data,
  output logic          irq_o
);
  logic          rst_ns;
  logic          clr_wr;
  logic          en_wr;
  logic [DW-1:0] en_d;
  logic [DW-1:0] en_q;
  logic [DW-1:0] causes_nxt;
  logic [DW-1:0] status_q;
  logic          norm_sum;
  logic          abn_sum;
  logic          irq_d;
  logic          irq_q;

  assign clr_wr = wr_en & (reg_sel_e'(wr_sel) == SEL_STATUS);
  assign en_wr  = wr_en & (reg_sel_e'(wr_sel) == SEL_ENABLE);

  nic_irq_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  nic_irq_enable_reg #(.DW(DW), .RST_VAL(EN_RST)) u_en (
    .clk      (clk),
    .rst_ns   (rst_ns),
    .soft_rst (soft_rst),
    .wr       (en_wr),
    .wr_data  (wr_data),
    .en_d     (en_d),
    .en_q     (en_q)
  );

  nic_irq_summary #(.DW(DW), .NORM_GRP(NORM_GRP), .ABN_GRP(ABN_GRP)) u_sum (
    .causes   (causes_nxt),
    .enables  (en_d),
    .norm_sum (norm_sum),
    .abn_sum  (abn_sum)
  );

  nic_irq_status_reg #(
    .DW(DW), .RST_VAL(STAT_RST), .EVT_MASK(EVT_MASK), .CLR_MASK(CLR_MASK),
    .NIS_BIT(NIS_BIT), .AIS_BIT(AIS_BIT)
  ) u_stat (
    .clk        (clk),
    .rst_ns     (rst_ns),
    .soft_rst   (soft_rst),
    .evt        (evt_i),
    .clr_wr     (clr_wr),
    .clr_data   (wr_data),
    .en_wr      (en_wr),
    .norm_sum   (norm_sum),
    .abn_sum    (abn_sum),
    .causes_nxt (causes_nxt),
    .status_q   (status_q)
  );

  always_comb begin
    irq_d = soft_rst ? 1'b0 : |(status_q & en_q & SUMM_MASK);
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) irq_q <= 1'b0;
    else         irq_q <= irq_d;
  end

  assign irq_o   = irq_q;
  assign rd_data = (reg_sel_e'(rd_sel) == SEL_ENABLE) ? en_q : status_q;
endmodule

// File: rtl/nic_irq_ctrl_chk.sv
module nic_irq_ctrl_chk
  import nic_irq_pkg::*;
(
  input logic          clk,
  input logic          rst_ns,
  input logic          soft_rst,
  input logic [DW-1:0] evt_i,
  input logic          wr_en,
  input logic          wr_sel,
  input logic [DW-1:0] wr_data,
  input logic [DW-1:0] status_q,
  input logic [DW-1:0] en_q,
  input logic          irq_o
);
  logic [DW-1:0] evt_m;
  logic [DW-1:0] kept_m;
  logic          want_irq;

  assign evt_m    = evt_i & EVT_MASK;
  assign kept_m   = status_q & EVT_MASK & ~((wr_en && !wr_sel) ? wr_data : '0);
  assign want_irq = |(status_q & en_q & SUMM_MASK);

  // R2 R9
  evt_lands_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    ((|evt_m) && !soft_rst) |=> ((status_q & $past(evt_m)) == $past(evt_m)));

  // R3
  fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    ((status_q & ~CLR_MASK) == (STAT_RST & ~CLR_MASK)));

  // R4
  norm_sum_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (status_q[NIS_BIT] == |(status_q & en_q & NORM_GRP)));

  // R5
  abn_sum_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (status_q[AIS_BIT] == |(status_q & en_q & ABN_GRP)));

  // R6
  kept_bits_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !soft_rst |=> (($past(kept_m) & ~status_q) == '0));

  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (want_irq && !soft_rst) |=> irq_o);

  // R8
  irq_low_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !want_irq |=> !irq_o);

  // R10
  soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    soft_rst |=> (status_q == STAT_RST && en_q == EN_RST && !irq_o));
endmodule

bind nic_irq_ctrl nic_irq_ctrl_chk u_chk (
  .clk      (clk),
  .rst_ns   (rst_ns),
  .soft_rst (soft_rst),
  .evt_i    (evt_i),
  .wr_en    (wr_en),
  .wr_sel   (wr_sel),
  .wr_data  (wr_data),
  .status_q (status_q),
  .en_q     (en_q),
  .irq_o    (irq_o)
);

// File: tb/sim_nic_irq_ctrl.sv
module sim_nic_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic [31:0] evt_i = '0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_sel = 1'b0;
  logic [31:0] rd_data;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  nic_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .evt_i(evt_i),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic rd(input logic sel, output logic [31:0] v);
    rd_sel = sel;
    #1;
    v = rd_data;
  endtask

  task automatic chk_stat(input string req, input logic [31:0] exp);
    logic [31:0] v;
    rd(1'b0, v);
    chk(req, v, exp);
  endtask

  task automatic chk_en(input string req, input logic [31:0] exp);
    logic [31:0] v;
    rd(1'b1, v);
    chk(req, v, exp);
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    step();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse(input logic [31:0] e);
    evt_i = e;
    step();
    evt_i = '0;
  endtask

  task automatic do_soft();
    soft_rst = 1'b1;
    step();
    soft_rst = 1'b0;
  endtask

  task automatic t_reset();
    chk_stat("R1 status", 32'hF000_0000);
    chk_en("R1 R11 enable", 32'hF3FE_0000);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_normal();
    do_soft();
    wr(1'b1, 32'h0001_0001);
    chk_en("R7 enable write", 32'h0001_0001);
    pulse(32'h1);
    chk_stat("R2 R4 normal event", 32'hF001_0001);
    chk("R8 irq not yet", {31'b0, irq_o}, 32'h0);
    step();
    chk("R8 irq raised", {31'b0, irq_o}, 32'h1);
    wr(1'b0, 32'h0001_0000);
    chk_stat("R6 summary rebuilt", 32'hF001_0001);
    wr(1'b0, 32'h0000_0001);
    chk_stat("R6 cause cleared", 32'hF000_0000);
    step();
    chk("R8 irq dropped", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_abnormal();
    do_soft();
    wr(1'b1, 32'h0800_8000);
    pulse(32'h0800_2000);
    chk_stat("R5 abnormal event", 32'hF800_A000);
    step();
    chk("R8 irq abnormal", {31'b0, irq_o}, 32'h1);
    wr(1'b1, 32'h0800_0000);
    chk_stat("R5 summary kept", 32'hF800_A000);
    step();
    chk("R8 summary not enabled", {31'b0, irq_o}, 32'h0);
    wr(1'b1, 32'h0);
    chk_stat("R5 R7 summary off", 32'hF800_2000);
  endtask

  task automatic t_ignored();
    do_soft();
    wr(1'b1, 32'hFFFF_FFFF);
    pulse(32'hF3FF_8000);
    chk_stat("R3 outside events ignored", 32'hF000_0000);
    step();
    chk("R3 irq stays low", {31'b0, irq_o}, 32'h0);
    wr(1'b0, 32'hF3FE_0000);
    chk_stat("R6 fixed bits not cleared", 32'hF000_0000);
    pulse(32'h4);
    chk_stat("R2 R4 second cause", 32'hF001_0004);
  endtask

  task automatic t_race();
    do_soft();
    wr(1'b1, 32'h0001_0040);
    pulse(32'h40);
    evt_i = 32'h40;
    wr(1'b0, 32'h40);
    evt_i = '0;
    chk_stat("R9 event beats clear", 32'hF001_0040);
    wr(1'b0, 32'h40);
    chk_stat("R6 later clear", 32'hF000_0000);
  endtask

  task automatic t_soft();
    do_soft();
    wr(1'b1, 32'h0001_0001);
    pulse(32'h1);
    step();
    chk("R8 irq before soft", {31'b0, irq_o}, 32'h1);
    soft_rst = 1'b1; evt_i = 32'h1;
    wr(1'b1, 32'h0000_FFFF);
    soft_rst = 1'b0; evt_i = '0;
    chk_stat("R10 status", 32'hF000_0000);
    chk_en("R10 enable", 32'hF3FE_0000);
    chk("R10 irq", {31'b0, irq_o}, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
    t_reset();
    t_normal();
    t_abnormal();
    t_ignored();
    t_race();
    t_soft();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule